// File: doc/BRIEF.md
# Receive Frame Sorter and Filter

This block sits on the receive side of a token-ring media access controller, between the byte stream that leaves the ring engine and three indicate channels that carry frames to memory. For every frame it decides which indicate channel receives the frame, or whether the frame is dropped. It bases that decision on three things: the frame type decoded from the frame-control byte, the destination-address match flags supplied by an external comparator, and an optional comparison against the last accepted management frame of the same type. The decision is made once per frame, on the beat that carries the last byte, and appears one cycle later on a status strobe.

The input is a valid/ready byte stream. `s_first` marks the frame-control byte and `s_last` marks the final byte. The address-match flags and the error flag are sampled together with the last byte. The block never applies back-pressure: `s_ready` is held high, so a beat is taken on every cycle in which `s_valid` is high. The upstream source may leave gaps of any length between beats, and there is no minimum gap between frames. The status outputs have no handshake; the consumer must capture them in the cycle `st_valid` is high.

Frame-type encoding of the frame-control byte `fc`:
- Void or token: `fc[5:0] == 0`.
- MAC: `fc[7]=1`, `fc[5:4]=00`, `fc[3:0]!=0`.
- Station management (SMT): `fc[7]=0`, `fc[5:4]=00`, `fc[3:0]!=0`.
- Every other value is a user frame.

Channel code 3 means that no channel receives the frame.

Top module: `rx_frame_sorter`

## Requirements
- R1: Each accepted beat with `s_last` high produces exactly one cycle of `st_valid`, in the following cycle. `st_valid` stays low at all other times, including in the middle of a frame. `s_ready` is always 1.
- R2: A frame whose frame-control byte has `fc[5:0]==0` (void or token) is discarded with `st_keep=0` and `st_chan=3`, whatever the address flags and modes are.
- R3: With `bridge_mode=1`, a non-void frame with `addr_ext_hit=1` goes to channel 2. This takes priority over an internal match and over the frame type.
- R4: A MAC or SMT frame with `addr_int_hit=1` that is not sent to channel 2 goes to channel 0.
- R5: A user frame with `addr_int_hit=1` that is not sent to channel 2 goes to channel 1.
- R6: A frame that matches no address in use is discarded with `st_chan=3`. With `bridge_mode=0`, `addr_ext_hit` is ignored.
- R7: With `dup_filter_en=1`, a MAC or SMT frame that would otherwise be kept is discarded (`st_keep=0`, `st_chan=3`, `st_dup=1`) when both of the following equal the values stored from the last kept error-free frame of the same type:
  - its byte count, including the frame-control byte;
  - its checksum `c`, where `c` starts at 0 and, for each byte b, becomes `{c[14:0],c[15]} ^ {8'h00,b}`.
  User frames are never flagged as duplicates, and a frame that differs in any byte is kept.
- R8: With `dup_filter_en=0`, no frame is flagged as a duplicate. Kept error-free MAC and SMT frames still update the stored reference.
- R9: MAC frames and SMT frames keep separate references, so an SMT frame in between does not disturb duplicate detection of MAC frames.
- R10: A frame ending with `s_err=1` is reported with `st_err=1` and sorted by R2 to R6. It is never flagged as a duplicate, and it clears both stored references, so the next identical frame is kept.
- R11: During and after reset `st_valid` is 0 and no reference is stored, so the first MAC or SMT frame after reset is never flagged as a duplicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Byte stream beat valid |
| s_ready | output | 1 | Always 1; the block takes every beat |
| s_data | input | 8 | Frame byte |
| s_first | input | 1 | Beat carries the frame-control byte |
| s_last | input | 1 | Beat carries the final byte of the frame |
| s_err | input | 1 | Frame ended with an error; sampled with `s_last` |
| addr_int_hit | input | 1 | Destination matched an internal short or long address; sampled with `s_last` |
| addr_ext_hit | input | 1 | Destination matched the external (bridged) address; sampled with `s_last` |
| bridge_mode | input | 1 | 1 selects bridging sort |
| dup_filter_en | input | 1 | 1 enables duplicate MAC/SMT suppression |
| st_valid | output | 1 | One-cycle status strobe per frame |
| st_chan | output | 2 | Indicate channel 0 to 2, or 3 for none |
| st_keep | output | 1 | Frame is to be kept |
| st_dup | output | 1 | Frame was dropped as a duplicate |
| st_err | output | 1 | Frame ended with an error |

## Verification
The hardest state to reach from the ports is the stored duplicate reference. It cannot be seen directly, and whether a later frame is flagged depends on which earlier frames were kept, of which type, and whether any of them ended in error. The bench reaches it with fixed sequences of byte-identical frames. It sends one MAC frame twice, puts an SMT frame between repeats, toggles the filter enable between repeats, and inserts an errored copy. Each time, the effect on the reference is read from the `st_dup` and `st_keep` outcome of the next identical frame.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {FT_VOID, FT_SMT, FT_MAC, FT_USER} ftype_e;

  localparam logic [1:0] CH_MGMT   = 2'd0;
  localparam logic [1:0] CH_LOCAL  = 2'd1;
  localparam logic [1:0] CH_BRIDGE = 2'd2;
  localparam logic [1:0] CH_NONE   = 2'd3;

  // Reference slot index per management type
  localparam int SLOT_SMT = 0;
  localparam int SLOT_MAC = 1;
  localparam int NSLOTS   = 2;

  function automatic ftype_e fc_class(input logic [7:0] fc);
    if (fc[5:0] == 6'd0)      return FT_VOID;
    else if (fc[5:4] == 2'b00) return fc[7] ? FT_MAC : FT_SMT;
    else                       return FT_USER;
  endfunction
endpackage

// File: rtl/rfs_accum.sv
module rfs_accum #(
  parameter int LEN_W = 12,
  parameter int SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             first,
  input  logic [7:0]       data,
  output logic [LEN_W-1:0] len_nxt,
  output logic [SUM_W-1:0] sum_nxt
);
  logic [LEN_W-1:0] len_q;
  logic [SUM_W-1:0] sum_q;
  logic [LEN_W-1:0] len_base;
  logic [SUM_W-1:0] sum_base;

  always_comb begin
    len_base = first ? '0 : len_q;
    sum_base = first ? '0 : sum_q;
    len_nxt  = len_base + LEN_W'(1);
    sum_nxt  = {sum_base[SUM_W-2:0], sum_base[SUM_W-1]} ^ SUM_W'(data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
      sum_q <= '0;
    end else if (beat) begin
      len_q <= len_nxt;
      sum_q <= sum_nxt;
    end
  end

  // A first byte always restarts the count at one
  a_r7_len_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && first) |=> (len_q == LEN_W'(1)));
endmodule

// File: rtl/rfs_dup_ref.sv
module rfs_dup_ref #(
  parameter int LEN_W  = 12,
  parameter int SUM_W  = 16,
  parameter int NSLOTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [NSLOTS-1:0] upd,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [SUM_W-1:0]  sum_in,
  output logic [NSLOTS-1:0] hit
);
  for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
    logic             vld_q;
    logic [LEN_W-1:0] len_q;
    logic [SUM_W-1:0] sum_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        len_q <= '0;
        sum_q <= '0;
      end else if (clr) begin
        vld_q <= 1'b0;
      end else if (upd[g]) begin
        vld_q <= 1'b1;
        len_q <= len_in;
        sum_q <= sum_in;
      end
    end

    assign hit[g] = vld_q && (len_q == len_in) && (sum_q == sum_in);

    // R10: an errored frame leaves no reference behind
    a_r10_clear_forgets: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !hit[g]);
  end
endmodule

// File: rtl/rx_frame_sorter.sv
module rx_frame_sorter
  import rfs_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int SUM_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_first,
  input  logic       s_last,
  input  logic       s_err,
  input  logic       addr_int_hit,
  input  logic       addr_ext_hit,
  input  logic       bridge_mode,
  input  logic       dup_filter_en,
  output logic       st_valid,
  output logic [1:0] st_chan,
  output logic       st_keep,
  output logic       st_dup,
  output logic       st_err
);
  logic             beat, end_beat;
  logic [7:0]       fc_q, fc_cur;
  ftype_e           ftype;
  logic             mgmt;
  int unsigned      slot;
  logic [LEN_W-1:0] len_nxt;
  logic [SUM_W-1:0] sum_nxt;
  logic [NSLOTS-1:0] ref_hit, ref_upd;
  logic             sort_keep, dup_hit, keep;
  logic [1:0]       sort_chan;

  assign s_ready  = 1'b1;
  assign beat     = s_valid && s_ready;
  assign end_beat = beat && s_last;

  always_ff @(posedge clk) begin
    if (!rst_n)             fc_q <= '0;
    else if (beat && s_first) fc_q <= s_data;
  end

  assign fc_cur = s_first ? s_data : fc_q;
  assign ftype  = fc_class(fc_cur);
  assign mgmt   = (ftype == FT_MAC) || (ftype == FT_SMT);
  assign slot   = (ftype == FT_MAC) ? SLOT_MAC : SLOT_SMT;

  rfs_accum #(.LEN_W(LEN_W), .SUM_W(SUM_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(s_first), .data(s_data),
    .len_nxt(len_nxt), .sum_nxt(sum_nxt)
  );

  // Sorting by type and address match
  always_comb begin
    sort_keep = 1'b0;
    sort_chan = CH_NONE;
    if (ftype != FT_VOID) begin
      if (bridge_mode && addr_ext_hit) begin
        sort_keep = 1'b1;
        sort_chan = CH_BRIDGE;
      end else if (addr_int_hit) begin
        sort_keep = 1'b1;
        sort_chan = mgmt ? CH_MGMT : CH_LOCAL;
      end
    end
  end

  assign dup_hit = dup_filter_en && mgmt && sort_keep && !s_err && ref_hit[slot];
  assign keep    = sort_keep && !dup_hit;

  always_comb begin
    ref_upd = '0;
    if (end_beat && keep && mgmt && !s_err) ref_upd[slot] = 1'b1;
  end

  rfs_dup_ref #(.LEN_W(LEN_W), .SUM_W(SUM_W), .NSLOTS(NSLOTS)) u_ref (
    .clk(clk), .rst_n(rst_n), .clr(end_beat && s_err), .upd(ref_upd),
    .len_in(len_nxt), .sum_in(sum_nxt), .hit(ref_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_chan  <= CH_NONE;
      st_keep  <= 1'b0;
      st_dup   <= 1'b0;
      st_err   <= 1'b0;
    end else begin
      st_valid <= end_beat;
      if (end_beat) begin
        st_chan <= keep ? sort_chan : CH_NONE;
        st_keep <= keep;
        st_dup  <= dup_hit;
        st_err  <= s_err;
      end
    end
  end

  a_r1_strobe_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    end_beat |=> st_valid);
  a_r1_strobe_only_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !$past(end_beat)) |-> 1'b0);
  a_r2_void_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (end_beat && ftype == FT_VOID) |=> (st_valid && !st_keep));
  a_r6_kept_has_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_keep) |-> (st_chan != CH_NONE));
  a_r7_dup_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    st_dup |-> (!st_keep && st_chan == CH_NONE));
  a_r10_err_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (end_beat && s_err) |=> (st_err && !st_dup));
endmodule

// File: tb/rx_frame_sorter_test.sv
module rx_frame_sorter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0, s_err = 1'b0;
  logic [7:0] s_data = '0;
  logic       addr_int_hit = 1'b0, addr_ext_hit = 1'b0;
  logic       bridge_mode = 1'b1, dup_filter_en = 1'b0;
  logic       s_ready, st_valid, st_keep, st_dup, st_err;
  logic [1:0] st_chan;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rx_frame_sorter uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_first(s_first), .s_last(s_last), .s_err(s_err),
    .addr_int_hit(addr_int_hit), .addr_ext_hit(addr_ext_hit),
    .bridge_mode(bridge_mode), .dup_filter_en(dup_filter_en),
    .st_valid(st_valid), .st_chan(st_chan), .st_keep(st_keep),
    .st_dup(st_dup), .st_err(st_err)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Sends one frame: fc then bytes base+1, base+2, ...; flags on last beat.
  task automatic send(input logic [7:0] fc, input int n, input logic [7:0] base,
                      input logic ih, input logic eh, input logic er);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) chk("R1 no strobe mid-frame", {7'd0, st_valid}, 8'd0);
      s_valid = 1'b1;
      s_first = (i == 0);
      s_last  = (i == n - 1);
      s_data  = (i == 0) ? fc : base + 8'(i);
      addr_int_hit = (i == n - 1) ? ih : 1'b0;
      addr_ext_hit = (i == n - 1) ? eh : 1'b0;
      s_err = (i == n - 1) ? er : 1'b0;
    end
    @(negedge clk);
    s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0; s_err = 1'b0;
    addr_int_hit = 1'b0; addr_ext_hit = 1'b0;
  endtask

  task automatic expect_st(input string tag, input logic keep, input logic [1:0] chan,
                           input logic dup, input logic err);
    chk({tag, " valid"}, {7'd0, st_valid}, 8'd1);
    chk({tag, " keep"},  {7'd0, st_keep},  {7'd0, keep});
    chk({tag, " chan"},  {6'd0, st_chan},  {6'd0, chan});
    chk({tag, " dup"},   {7'd0, st_dup},   {7'd0, dup});
    chk({tag, " err"},   {7'd0, st_err},   {7'd0, err});
  endtask

  task automatic t_reset;
    chk("R11 reset strobe low", {7'd0, st_valid}, 8'd0);
    chk("R1 ready high", {7'd0, s_ready}, 8'd1);
  endtask

  task automatic t_dup_chain;
    dup_filter_en = 1'b1; bridge_mode = 1'b1;
    send(8'hC2, 5, 8'h10, 1, 0, 0); expect_st("R11 first MAC after reset", 1, 2'd0, 0, 0);
    send(8'hC2, 5, 8'h10, 1, 0, 0); expect_st("R7 MAC repeat dropped", 0, 2'd3, 1, 0);
    send(8'h41, 4, 8'h30, 1, 0, 0); expect_st("R4 SMT kept", 1, 2'd0, 0, 0);
    send(8'hC2, 5, 8'h10, 1, 0, 0); expect_st("R9 MAC still duplicate after SMT", 0, 2'd3, 1, 0);
    send(8'hC2, 5, 8'h11, 1, 0, 0); expect_st("R7 changed byte kept", 1, 2'd0, 0, 0);
    dup_filter_en = 1'b0;
    send(8'hC2, 5, 8'h11, 1, 0, 0); expect_st("R8 filter off keeps repeat", 1, 2'd0, 0, 0);
    dup_filter_en = 1'b1;
    send(8'hC2, 5, 8'h11, 1, 0, 0); expect_st("R8 reference kept while off", 0, 2'd3, 1, 0);
    send(8'hC2, 5, 8'h11, 1, 0, 1); expect_st("R10 errored copy reported", 1, 2'd0, 0, 1);
    send(8'hC2, 5, 8'h11, 1, 0, 0); expect_st("R10 reference cleared", 1, 2'd0, 0, 0);
    send(8'h51, 3, 8'h20, 1, 0, 0); expect_st("R7 user frame first", 1, 2'd1, 0, 0);
    send(8'h51, 3, 8'h20, 1, 0, 0); expect_st("R7 user repeat not dup", 1, 2'd1, 0, 0);
    send(8'hC3, 1, 8'h00, 1, 0, 0); expect_st("R4 one-byte MAC", 1, 2'd0, 0, 0);
    send(8'hC3, 1, 8'h00, 1, 0, 0); expect_st("R7 one-byte MAC repeat", 0, 2'd3, 1, 0);
    dup_filter_en = 1'b0;
  endtask

  task automatic t_bridge_sort;
    bridge_mode = 1'b1;
    send(8'h50, 6, 8'h40, 1, 1, 0); expect_st("R3 external wins", 1, 2'd2, 0, 0);
    send(8'hC2, 3, 8'h44, 1, 1, 0); expect_st("R3 external MAC", 1, 2'd2, 0, 0);
    send(8'h41, 3, 8'h48, 1, 0, 0); expect_st("R4 internal SMT", 1, 2'd0, 0, 0);
    send(8'h55, 4, 8'h4C, 1, 0, 0); expect_st("R5 internal user", 1, 2'd1, 0, 0);
    send(8'h55, 4, 8'h4C, 0, 0, 0); expect_st("R6 no match dropped", 0, 2'd3, 0, 0);
    @(negedge clk);
    chk("R1 strobe one cycle", {7'd0, st_valid}, 8'd0);
  endtask

  task automatic t_void;
    send(8'h40, 3, 8'h60, 1, 1, 0); expect_st("R2 void dropped", 0, 2'd3, 0, 0);
    send(8'h80, 2, 8'h64, 1, 0, 0); expect_st("R2 token dropped", 0, 2'd3, 0, 0);
  endtask

  task automatic t_normal_mode;
    bridge_mode = 1'b0;
    send(8'h50, 4, 8'h70, 0, 1, 0); expect_st("R6 external ignored", 0, 2'd3, 0, 0);
    send(8'h50, 4, 8'h70, 1, 1, 0); expect_st("R5 internal user, normal mode", 1, 2'd1, 0, 0);
    send(8'hC2, 4, 8'h74, 1, 1, 0); expect_st("R4 MAC, normal mode", 1, 2'd0, 0, 0);
    bridge_mode = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_dup_chain();
    t_bridge_sort();
    t_void();
    t_normal_mode();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule